// File: doc/BRIEF.md
# UART Status and Interrupt Register File

This block is the software-visible face of a UART. A host reaches it through a plain register bus with a word address, read and write strobes, and a 32-bit data word. It holds seven 16-bit configuration registers and two flag registers. It also holds a read-only test-status word that mirrors the receive-empty input and the transmit-empty flag. Receive-side logic signals events on single-cycle pulse inputs, and each pulse raises a sticky flag. Software clears a flag by writing 1 to its bit.

Each flag is masked with an enable bit and the results are merged into one interrupt line. The enables sit in three different control registers. A write to the data offset while the transmitter is enabled hands the low byte to an external serializer as a one-cycle pulse. It also drops the transmit-ready, transmit-complete and TX-empty flags, which come back when the serializer reports completion. The serializer, baud generator and receive FIFO are outside this block.

Word offsets are as follows:
- 0: data (write only; reads return 0)
- 1: CTRL1
- 2: CTRL2
- 3: CTRL3
- 4: CTRL4
- 5: FIFO control
- 6: FLAGS_A
- 7: FLAGS_B
- 8: baud modulator
- 9: baud count
- 10: test status

Top module: `uart_regfile`

## Requirements
- R1: After reset the registers read as follows, with dcd_in=1 and rx_empty=1. FLAGS_A=0x2040 (transmit-ready bit 13, RX-idle bit 6). FLAGS_B=0x4028 (TX-empty bit 14, carrier-detect bit 5, transmit-complete bit 3). CTRL1=0, CTRL2=0x0001 (soft-reset bit 0), CTRL3=0x0700, CTRL4=0, FIFO control=0x0801, baud count=4, test status=0x0060. Also irq=0 and tx_valid=0.
- R2: A write to a configuration register (offsets 1-5, 8, 9) stores only wdata[15:0], and a read returns it with bits 31:16 zero.
- R3: A write to FLAGS_A or FLAGS_B clears exactly the bits written as 1 and leaves the others. FLAGS_B bit 5 always shows dcd_in and cannot be cleared.
- R4: Each event pulse sets its flag on the next edge: ev_rrdy sets FLAGS_A bit 9, ev_age sets FLAGS_A bit 8, ev_wake sets FLAGS_B bit 7, ev_ore sets FLAGS_B bit 1 and ev_rdr sets FLAGS_B bit 0. A set and a write-one-to-clear of the same bit in one cycle leave it set.
- R5: FLAGS_A bits 13 and 9 raise irq when the same bit of CTRL1 is 1.
- R6: FLAGS_A bit 8 raises irq only while CTRL2 bit 3 is 1.
- R7: FLAGS_B bit 14 raises irq only while CTRL1 bit 6 is 1.
- R8: FLAGS_B bits 7, 3, 1 and 0 raise irq when the same bit of CTRL4 is 1. irq is the OR of all enabled sources and is 0 when none is enabled.
- R9: A write to offset 0 while CTRL2 bit 2 is 1 gives, after that edge, tx_valid high for exactly one cycle with tx_byte = wdata[7:0]. At the same edge it clears FLAGS_A bit 13 and FLAGS_B bits 14 and 3.
- R10: A tx_done pulse sets FLAGS_A bit 13 and FLAGS_B bits 14 and 3. If a transmit write is accepted in the same cycle, the write wins: a new pulse is issued and the flags end cleared.
- R11: A write to offset 0 while CTRL2 bit 2 is 0 issues no pulse and sets FLAGS_A bit 13 and FLAGS_B bits 14 and 3.
- R12: Reads of offsets 11-15 return 0. Writes there change no register.
- R13: Test status bit 5 shows rx_empty and bit 6 shows FLAGS_B bit 14. All other test-status bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Word offset of the access |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe; rdata is 0 when low |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, combinational from addr |
| irq | output | 1 | Merged interrupt |
| tx_valid | output | 1 | One-cycle byte hand-off to the serializer |
| tx_byte | output | 8 | Byte that goes with tx_valid |
| tx_done | input | 1 | Serializer finished the byte |
| ev_rrdy | input | 1 | Receive level reached pulse |
| ev_age | input | 1 | Receive ageing timeout pulse |
| ev_rdr | input | 1 | Receive data present pulse |
| ev_ore | input | 1 | Receive overrun pulse |
| ev_wake | input | 1 | Wake edge pulse |
| rx_empty | input | 1 | Receive FIFO empty level |
| dcd_in | input | 1 | Carrier-detect level |

## Verification
Two pairs of actions can hit the same flag bit in the same cycle. The first pair is a hardware event and a software write-one-to-clear. The bench raises ev_ore on the very cycle that writes 1 to the overrun bit, and expects the flag to stay set. The second pair is a serializer completion and a new transmit write. The bench pulses tx_done on the cycle that writes the data offset. It expects a fresh byte pulse and transmit-ready left low, since the queued byte must not be reported as done.

// File: rtl/uart_regs_pkg.sv
package uart_regs_pkg;
  localparam int REG_W = 16;

  // word offsets with a fixed meaning
  localparam int OFS_DATA = 0;
  localparam int OFS_FLA  = 6;
  localparam int OFS_FLB  = 7;
  localparam int OFS_TEST = 10;

  // configuration register slots
  localparam int NCFG   = 7;
  localparam int CFG_C1 = 0;
  localparam int CFG_C2 = 1;
  localparam int CFG_C4 = 3;

  // flag and enable bit positions (enable bits share positions with flags)
  localparam int FA_TRDY   = 13;
  localparam int FA_RRDY   = 9;
  localparam int FA_AGE    = 8;
  localparam int FA_RXIDLE = 6;
  localparam int FB_TXFE   = 14;
  localparam int FB_WAKE   = 7;
  localparam int FB_DCD    = 5;
  localparam int FB_TXDC   = 3;
  localparam int FB_ORE    = 1;
  localparam int FB_RDR    = 0;
  localparam int C1_TXE_IE = 6;
  localparam int C2_TXEN   = 2;
  localparam int C2_AGE_IE = 3;
  localparam int TS_RXEMPTY = 5;
  localparam int TS_TXEMPTY = 6;

  localparam logic [REG_W-1:0] FA_IRQ_MASK = REG_W'((1 << FA_TRDY) | (1 << FA_RRDY));
  localparam logic [REG_W-1:0] FB_IRQ_MASK =
    REG_W'((1 << FB_WAKE) | (1 << FB_TXDC) | (1 << FB_ORE) | (1 << FB_RDR));

  function automatic int cfg_offset(input int i);
    case (i)
      0: return 1;
      1: return 2;
      2: return 3;
      3: return 4;
      4: return 5;
      5: return 8;
      default: return 9;
    endcase
  endfunction

  function automatic logic [REG_W-1:0] cfg_reset(input int i);
    case (i)
      1: return REG_W'(16'h0001);
      2: return REG_W'(16'h0700);
      4: return REG_W'(16'h0801);
      6: return REG_W'(16'h0004);
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/uart_cfg_reg.sv
module uart_cfg_reg #(
  parameter int W = 16,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= RST;
    else if (we_i) q <= d_i;
  end

  assign q_o = q;
endmodule

// File: rtl/uart_flag_reg.sv
module uart_flag_reg #(
  parameter int W = 16,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q, d;
  logic         en;

  // set dominates clear
  always_comb begin
    en = |(set_i | clr_i);
    d  = (q & ~clr_i) | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= RST;
    else if (en) q <= d;
  end

  assign q_o = q;
endmodule

// File: rtl/uart_tx_handshake.sv
module uart_tx_handshake #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              data_wr_i,
  input  logic              tx_en_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              done_i,
  output logic              valid_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              flag_clr_o,
  output logic              flag_set_o
);
  logic              accept;
  logic              valid_q;
  logic [BYTE_W-1:0] byte_q;

  always_comb begin
    accept     = data_wr_i & tx_en_i;
    flag_clr_o = accept;
    flag_set_o = (done_i & ~accept) | (data_wr_i & ~tx_en_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= accept;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      byte_q <= '0;
    else if (accept) byte_q <= byte_i;
  end

  assign valid_o = valid_q;
  assign byte_o  = byte_q;
endmodule

// File: rtl/uart_irq_merge.sv
module uart_irq_merge #(
  parameter int W = 16
) (
  input  logic [W-1:0] fa_i,
  input  logic [W-1:0] fa_en_i,
  input  logic [W-1:0] fb_i,
  input  logic [W-1:0] fb_en_i,
  output logic         irq_o
);
  logic [W-1:0] hit_a, hit_b;

  for (genvar b = 0; b < W; b++) begin : g_bit
    assign hit_a[b] = fa_i[b] & fa_en_i[b];
    assign hit_b[b] = fb_i[b] & fb_en_i[b];
  end

  assign irq_o = |hit_a | |hit_b;
endmodule

// File: rtl/uart_regfile.sv
module uart_regfile
  import uart_regs_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int REG_W  = uart_regs_pkg::REG_W,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_byte,
  input  logic              tx_done,
  input  logic              ev_rrdy,
  input  logic              ev_age,
  input  logic              ev_rdr,
  input  logic              ev_ore,
  input  logic              ev_wake,
  input  logic              rx_empty,
  input  logic              dcd_in
);
  localparam logic [REG_W-1:0] FA_RST = REG_W'((1 << FA_TRDY) | (1 << FA_RXIDLE));
  localparam logic [REG_W-1:0] FB_RST = REG_W'((1 << FB_TXFE) | (1 << FB_TXDC));
  localparam logic [REG_W-1:0] FB_DCD_M = REG_W'(1 << FB_DCD);
  localparam logic [REG_W-1:0] TX_FA_M  = REG_W'(1 << FA_TRDY);
  localparam logic [REG_W-1:0] TX_FB_M  = REG_W'((1 << FB_TXFE) | (1 << FB_TXDC));

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync;
  logic       srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign srst_n = rst_sync[1];

  logic unused_hi;
  assign unused_hi = ^wdata[DATA_W-1:REG_W];

  int unsigned ofs;
  assign ofs = int'(addr);

  // configuration registers
  logic [REG_W-1:0] cfg_q [NCFG];
  for (genvar g = 0; g < NCFG; g++) begin : g_cfg
    logic we;
    assign we = wr_en && (ofs == cfg_offset(g));
    uart_cfg_reg #(.W(REG_W), .RST(cfg_reset(g))) u_reg (
      .clk(clk), .rst_n(srst_n), .we_i(we),
      .d_i(wdata[REG_W-1:0]), .q_o(cfg_q[g])
    );
  end

  logic [REG_W-1:0] ctrl1_q, ctrl2_q, ctrl4_q;
  assign ctrl1_q = cfg_q[CFG_C1];
  assign ctrl2_q = cfg_q[CFG_C2];
  assign ctrl4_q = cfg_q[CFG_C4];

  // transmit hand-off
  logic tx_clr, tx_set;
  uart_tx_handshake #(.BYTE_W(BYTE_W)) u_tx (
    .clk(clk), .rst_n(srst_n),
    .data_wr_i(wr_en && (ofs == OFS_DATA)),
    .tx_en_i(ctrl2_q[C2_TXEN]),
    .byte_i(wdata[BYTE_W-1:0]),
    .done_i(tx_done),
    .valid_o(tx_valid), .byte_o(tx_byte),
    .flag_clr_o(tx_clr), .flag_set_o(tx_set)
  );

  // flag registers
  logic [REG_W-1:0] fa_set, fa_clr, fb_set, fb_clr, st1_q, st2_raw, st2_q;
  always_comb begin
    fa_set = '0;
    fa_set[FA_RRDY] = ev_rrdy;
    fa_set[FA_AGE]  = ev_age;
    fa_set = fa_set | (tx_set ? TX_FA_M : '0);
    fa_clr = ((wr_en && ofs == OFS_FLA) ? wdata[REG_W-1:0] : '0) | (tx_clr ? TX_FA_M : '0);

    fb_set = '0;
    fb_set[FB_WAKE] = ev_wake;
    fb_set[FB_ORE]  = ev_ore;
    fb_set[FB_RDR]  = ev_rdr;
    fb_set = fb_set | (tx_set ? TX_FB_M : '0);
    fb_clr = (((wr_en && ofs == OFS_FLB) ? wdata[REG_W-1:0] : '0) & ~FB_DCD_M)
           | (tx_clr ? TX_FB_M : '0);
  end

  uart_flag_reg #(.W(REG_W), .RST(FA_RST)) u_fla (
    .clk(clk), .rst_n(srst_n), .set_i(fa_set), .clr_i(fa_clr), .q_o(st1_q)
  );
  uart_flag_reg #(.W(REG_W), .RST(FB_RST)) u_flb (
    .clk(clk), .rst_n(srst_n), .set_i(fb_set), .clr_i(fb_clr), .q_o(st2_raw)
  );
  assign st2_q = (st2_raw & ~FB_DCD_M) | (dcd_in ? FB_DCD_M : '0);

  // interrupt enables gathered from three control registers
  logic [REG_W-1:0] fa_en, fb_en;
  always_comb begin
    fa_en = ctrl1_q & FA_IRQ_MASK;
    fa_en[FA_AGE] = ctrl2_q[C2_AGE_IE];
    fb_en = ctrl4_q & FB_IRQ_MASK;
    fb_en[FB_TXFE] = ctrl1_q[C1_TXE_IE];
  end

  uart_irq_merge #(.W(REG_W)) u_irq (
    .fa_i(st1_q), .fa_en_i(fa_en), .fb_i(st2_q), .fb_en_i(fb_en), .irq_o(irq)
  );

  // read path
  logic [REG_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NCFG; i++)
      if (ofs == cfg_offset(i)) rd_mux = cfg_q[i];
    if (ofs == OFS_FLA) rd_mux = st1_q;
    if (ofs == OFS_FLB) rd_mux = st2_q;
    if (ofs == OFS_TEST) begin
      rd_mux[TS_RXEMPTY] = rx_empty;
      rd_mux[TS_TXEMPTY] = st2_q[FB_TXFE];
    end
  end

  assign rdata = rd_en ? {{(DATA_W-REG_W){1'b0}}, rd_mux} : '0;
endmodule

// File: rtl/uart_regfile_chk.sv
module uart_regfile_chk
  import uart_regs_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int REG_W  = 16
) (
  input logic              clk,
  input logic              srst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic              tx_done,
  input logic              ev_ore,
  input logic              irq,
  input logic              tx_valid,
  input logic [REG_W-1:0]  st1_q,
  input logic [REG_W-1:0]  st2_q,
  input logic [REG_W-1:0]  ctrl1_q,
  input logic [REG_W-1:0]  ctrl2_q,
  input logic [REG_W-1:0]  ctrl4_q
);
  logic data_wr;
  assign data_wr = wr_en && (addr == '0);

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!srst_n)
    tx_valid |=> !tx_valid);

  a_r9_accept_pulses: assert property (@(posedge clk) disable iff (!srst_n)
    (data_wr && ctrl2_q[C2_TXEN]) |=> (tx_valid && !st1_q[FA_TRDY]));

  a_r10_done_sets: assert property (@(posedge clk) disable iff (!srst_n)
    (tx_done && !data_wr) |=> (st1_q[FA_TRDY] && st2_q[FB_TXDC] && st2_q[FB_TXFE]));

  a_r4_ore_sticks: assert property (@(posedge clk) disable iff (!srst_n)
    ev_ore |=> st2_q[FB_ORE]);

  a_r5_flags_a_irq: assert property (@(posedge clk) disable iff (!srst_n)
    (|(st1_q & ctrl1_q & FA_IRQ_MASK)) |-> irq);

  a_r8_flags_b_irq: assert property (@(posedge clk) disable iff (!srst_n)
    (|(st2_q & ctrl4_q & FB_IRQ_MASK)) |-> irq);

  a_r8_quiet_when_masked: assert property (@(posedge clk) disable iff (!srst_n)
    (ctrl1_q == '0 && ctrl4_q == '0 && !ctrl2_q[C2_AGE_IE]) |-> !irq);
endmodule

bind uart_regfile uart_regfile_chk #(.ADDR_W(ADDR_W), .REG_W(REG_W)) u_chk (
  .clk(clk), .srst_n(srst_n), .wr_en(wr_en), .addr(addr),
  .tx_done(tx_done), .ev_ore(ev_ore), .irq(irq), .tx_valid(tx_valid),
  .st1_q(st1_q), .st2_q(st2_q), .ctrl1_q(ctrl1_q), .ctrl2_q(ctrl2_q),
  .ctrl4_q(ctrl4_q)
);

// File: tb/sim_uart_regfile.sv
`timescale 1ns/1ps
module sim_uart_regfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, tx_valid;
  logic [7:0]  tx_byte;
  logic        tx_done = 1'b0;
  logic        ev_rrdy = 1'b0, ev_age = 1'b0, ev_rdr = 1'b0, ev_ore = 1'b0, ev_wake = 1'b0;
  logic        rx_empty = 1'b1, dcd_in = 1'b1;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];
  bit done_flag = 0;

  always #2.5 clk = ~clk;

  uart_regfile u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .irq(irq), .tx_valid(tx_valid),
    .tx_byte(tx_byte), .tx_done(tx_done), .ev_rrdy(ev_rrdy), .ev_age(ev_age),
    .ev_rdr(ev_rdr), .ev_ore(ev_ore), .ev_wake(ev_wake),
    .rx_empty(rx_empty), .dcd_in(dcd_in)
  );

  // monitor: every byte pulse is matched against the expected queue (R9)
  always @(negedge clk) begin
    if (rst_n && tx_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R9 unexpected tx pulse: actual %h expected none", tx_byte);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        if (tx_byte !== e) begin
          errors++;
          $display("FAIL R9 tx_byte: actual %h expected %h", tx_byte, e);
        end
      end
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    addr = 4'(a); wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // driver for transmit writes: records the byte the monitor must see
  task automatic tx_wr(input logic [31:0] d, input bit expect_pulse);
    if (expect_pulse) exp_q.push_back(d[7:0]);
    wr(0, d);
  endtask

  task automatic rd_chk(input int a, input logic [31:0] e, input string tag);
    #1;
    addr = 4'(a); rd_en = 1'b1;
    #1;
    checks++;
    if (rdata !== e) begin
      errors++;
      $display("FAIL %s read @%0d: actual %h expected %h", tag, a, rdata, e);
    end
    rd_en = 1'b0;
  endtask

  task automatic bit_chk(input logic act, input logic e, input string tag);
    #1;
    checks++;
    if (act !== e) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, e);
    end
  endtask

  task automatic pulse_ore_with_clear();
    @(negedge clk);
    addr = 4'd7; wdata = 32'h0002; wr_en = 1'b1; ev_ore = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; ev_ore = 1'b0;
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk);
    s = 1'b1;
    @(negedge clk);
    s = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd_chk(6, 32'h2040, "R1");
    rd_chk(7, 32'h4028, "R1");
    rd_chk(1, 32'h0000, "R1");
    rd_chk(2, 32'h0001, "R1");
    rd_chk(3, 32'h0700, "R1");
    rd_chk(4, 32'h0000, "R1");
    rd_chk(5, 32'h0801, "R1");
    rd_chk(9, 32'h0004, "R1");
    rd_chk(10, 32'h0060, "R1");
    bit_chk(irq, 1'b0, "R1 irq");
    bit_chk(tx_valid, 1'b0, "R1 tx_valid");

    // R2 upper half dropped
    wr(3, 32'hABCD_1234); rd_chk(3, 32'h1234, "R2");
    wr(5, 32'hFFFF_0005); rd_chk(5, 32'h0005, "R2");
    wr(8, 32'h5A5A_00C3); rd_chk(8, 32'h00C3, "R2");

    // R12 unmapped
    wr(12, 32'hFFFF_FFFF);
    rd_chk(12, 32'h0, "R12");
    rd_chk(15, 32'h0, "R12");
    rd_chk(3, 32'h1234, "R12");
    rd_chk(6, 32'h2040, "R12");
    rd_chk(7, 32'h4028, "R12");

    // R3 write-one-to-clear
    wr(6, 32'h0040); rd_chk(6, 32'h2000, "R3");
    wr(7, 32'h0020); rd_chk(7, 32'h4028, "R3 dcd");
    dcd_in = 1'b0;   rd_chk(7, 32'h4008, "R3 dcd live");
    dcd_in = 1'b1;

    // R4 events and set-over-clear
    pulse(ev_ore);   rd_chk(7, 32'h402A, "R4 ore");
    wr(7, 32'h0002); rd_chk(7, 32'h4028, "R4 clear");
    pulse_ore_with_clear(); rd_chk(7, 32'h402A, "R4 set wins");
    pulse(ev_wake);  rd_chk(7, 32'h40AA, "R4 wake");
    pulse(ev_rdr);   rd_chk(7, 32'h40AB, "R4 rdr");
    wr(7, 32'h0081); rd_chk(7, 32'h402A, "R4 clear pair");

    // R8 enables in CTRL4
    wr(4, 32'h0002); bit_chk(irq, 1'b1, "R8 ore enabled");
    wr(7, 32'h0002); bit_chk(irq, 1'b0, "R8 ore cleared");
    wr(4, 32'h0008); bit_chk(irq, 1'b1, "R8 txdc enabled");
    wr(4, 32'h0000); bit_chk(irq, 1'b0, "R8 all masked");

    // R5 enables in CTRL1
    wr(1, 32'h2000); bit_chk(irq, 1'b1, "R5 trdy");
    wr(1, 32'h0200); bit_chk(irq, 1'b0, "R5 rrdy idle");
    pulse(ev_rrdy);  bit_chk(irq, 1'b1, "R5 rrdy set");
    wr(6, 32'h0200); bit_chk(irq, 1'b0, "R5 rrdy cleared");
    wr(1, 32'h0000);

    // R6 ageing gated by CTRL2 bit 3
    pulse(ev_age);   rd_chk(6, 32'h2100, "R6 flag");
    bit_chk(irq, 1'b0, "R6 masked");
    wr(2, 32'h0009); bit_chk(irq, 1'b1, "R6 enabled");
    wr(2, 32'h0001); bit_chk(irq, 1'b0, "R6 disabled");
    wr(6, 32'h0100);

    // R7 TX-empty gated by CTRL1 bit 6
    wr(1, 32'h0040); bit_chk(irq, 1'b1, "R7 enabled");
    wr(1, 32'h0000); bit_chk(irq, 1'b0, "R7 disabled");

    // R11 transmit disabled
    wr(6, 32'h2000); wr(7, 32'h4008);
    rd_chk(6, 32'h0000, "R11 pre");
    rd_chk(7, 32'h0020, "R11 pre");
    tx_wr(32'h55, 1'b0);
    bit_chk(tx_valid, 1'b0, "R11 no pulse");
    rd_chk(6, 32'h2000, "R11");
    rd_chk(7, 32'h4028, "R11");

    // R9 transmit enabled
    wr(2, 32'h0005);
    tx_wr(32'h1A5, 1'b1);
    bit_chk(tx_valid, 1'b1, "R9 pulse");
    rd_chk(6, 32'h0000, "R9 trdy low");
    rd_chk(7, 32'h0020, "R9 flags low");
    bit_chk(tx_valid, 1'b0, "R9 one cycle");

    // R13 test status
    rd_chk(10, 32'h0020, "R13");
    rx_empty = 1'b0; rd_chk(10, 32'h0000, "R13");

    // R10 completion
    pulse(tx_done);
    rd_chk(6, 32'h2000, "R10");
    rd_chk(7, 32'h4028, "R10");
    rd_chk(10, 32'h0040, "R13 txempty");

    // R10 done and new write in one cycle
    exp_q.push_back(8'h3C);
    @(negedge clk);
    addr = 4'd0; wdata = 32'h3C; wr_en = 1'b1; tx_done = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; tx_done = 1'b0;
    bit_chk(tx_valid, 1'b1, "R10 write wins pulse");
    rd_chk(6, 32'h0000, "R10 write wins");
    pulse(tx_done);
    rd_chk(6, 32'h2000, "R10 final");

    repeat (2) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R9 missing pulses: actual %0d pending expected 0", exp_q.size());
    end

    done_flag = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done_flag) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule